// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding and Hazard Control

This block is the purely combinational steering logic for a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. Operands are read in decode. For every source register of the instruction in decode, the block compares the register number against the destination held by each older instruction in execute, memory and writeback. It then reports, for each operand, which of those stages supplies the value. If none of them does, the operand comes from the register file.

The register file gives no internal bypass. A value being written back in the same cycle as the read must therefore be steered from writeback. A load sitting in execute cannot supply its data in time. In that case the block holds fetch and decode for one cycle and injects a nop into execute. On the next cycle the load sits in memory and is forwarded from there.

A branch found mispredicted in execute squashes the two younger instructions, which are in decode and fetch. That squash overrides any load-use stall raised in the same cycle.

Top module: `hazard_unit`

## Requirements
- R1: Each operand has a 2-bit select in `fwd_sel`, where operand i occupies bits [2i+1:2i]. The codes are 00 for the register file, 01 for execute, 10 for memory and 11 for writeback. A source matching exactly one producing stage selects that stage.
- R2: When several producing stages match one source, the youngest wins. Execute beats memory, and memory beats writeback.
- R3: Register number 15 (all ones) means "no register". A source or destination of 15 never matches, never forwards and never stalls.
- R4: A stage is a producer only when both its valid and its write-enable bits are 1. Otherwise its destination is ignored for forwarding and for stalls.
- R5: A source matching only the writeback destination selects 11, never the register file.
- R6: A load producer in execute that matches any source raises `stall_fd` and `bubble_ex` together. The forward select still names execute.
- R7: A load in the memory stage causes no stall. A matching source selects 10.
- R8: `ex_mispredict` raises `flush_dec` and `flush_fetch` together and forces `stall_fd` and `bubble_ex` low.
- R9: With every stage invalid, as after reset, all selects are 00 and every control output is 0.
- R10: Each operand is resolved independently. One operand may forward from one stage while the other forwards from a different stage or reads the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_ids | input | N_SRC*REG_W | Source register numbers in decode, operand i in bits [REG_W*i+REG_W-1:REG_W*i] |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_W | Destination register in memory stage |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_wen | input | 1 | Memory instruction writes a register |
| wb_dst | input | REG_W | Destination register in writeback stage |
| wb_valid | input | 1 | Writeback stage holds a real instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| ex_mispredict | input | 1 | Branch in execute was mispredicted |
| fwd_sel | output | 2*N_SRC | Per-operand forward selects |
| stall_fd | output | 1 | Hold fetch and decode this cycle |
| bubble_ex | output | 1 | Inject a nop into execute |
| flush_dec | output | 1 | Squash the decode instruction |
| flush_fetch | output | 1 | Squash the fetch instruction |

## Verification
The bench builds the block with its defaults: 4-bit register numbers and two source operands. With 16 register numbers, an exhaustive sweep of every number through each stage is practical, and the reserved number 15 is hit directly. Two operands are enough to show independent resolution, with one operand stalling or forwarding while the other does not.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_EX  = 2'b01,
        FWD_MEM = 2'b10,
        FWD_WB  = 2'b11
    } fwd_sel_e;

    typedef struct packed {
        fwd_sel_e sel;
        logic     ex_hit;
    } match_t;

    typedef struct packed {
        logic stall;
        logic bubble;
        logic flush_dec;
        logic flush_fetch;
    } ctrl_t;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
    import hz_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic [REG_W-1:0] src_id,
    input  logic [REG_W-1:0] ex_dst,
    input  logic [REG_W-1:0] mem_dst,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             ex_prod,
    input  logic             mem_prod,
    input  logic             wb_prod,
    output fwd_sel_e         sel,
    output logic             ex_hit
);
    localparam logic [REG_W-1:0] NONE_ID = {REG_W{1'b1}};

    match_t res_d;
    logic   src_real;
    logic   hit_ex, hit_mem, hit_wb;

    always_comb begin
        src_real = (src_id != NONE_ID);
        hit_ex   = src_real && ex_prod  && (ex_dst  == src_id);
        hit_mem  = src_real && mem_prod && (mem_dst == src_id);
        hit_wb   = src_real && wb_prod  && (wb_dst  == src_id);

        res_d.ex_hit = hit_ex;
        // youngest producer wins
        if (hit_ex)       res_d.sel = FWD_EX;
        else if (hit_mem) res_d.sel = FWD_MEM;
        else if (hit_wb)  res_d.sel = FWD_WB;
        else              res_d.sel = FWD_RF;
    end

    assign sel    = res_d.sel;
    assign ex_hit = res_d.ex_hit;
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
(
    input  logic ld_use_hit,
    input  logic mispredict,
    output logic stall,
    output logic bubble,
    output logic flush_dec,
    output logic flush_fetch
);
    ctrl_t ctl_d;

    always_comb begin
        ctl_d = '0;
        if (mispredict) begin
            // squash wins over the load-use hold
            ctl_d.flush_dec   = 1'b1;
            ctl_d.flush_fetch = 1'b1;
        end else if (ld_use_hit) begin
            ctl_d.stall  = 1'b1;
            ctl_d.bubble = 1'b1;
        end
    end

    assign stall       = ctl_d.stall;
    assign bubble      = ctl_d.bubble;
    assign flush_dec   = ctl_d.flush_dec;
    assign flush_fetch = ctl_d.flush_fetch;
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hz_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int N_SRC = 2
) (
    input  logic [N_SRC*REG_W-1:0] dec_src_ids,
    input  logic [REG_W-1:0]       ex_dst,
    input  logic                   ex_valid,
    input  logic                   ex_wen,
    input  logic                   ex_load,
    input  logic [REG_W-1:0]       mem_dst,
    input  logic                   mem_valid,
    input  logic                   mem_wen,
    input  logic [REG_W-1:0]       wb_dst,
    input  logic                   wb_valid,
    input  logic                   wb_wen,
    input  logic                   ex_mispredict,
    output logic [2*N_SRC-1:0]     fwd_sel,
    output logic                   stall_fd,
    output logic                   bubble_ex,
    output logic                   flush_dec,
    output logic                   flush_fetch
);
    logic             ex_prod, mem_prod, wb_prod;
    logic [N_SRC-1:0] ex_hits;
    logic             ld_use_d;

    always_comb begin
        ex_prod  = ex_valid  & ex_wen;
        mem_prod = mem_valid & mem_wen;
        wb_prod  = wb_valid  & wb_wen;
        ld_use_d = ex_load & (|ex_hits);
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        fwd_sel_e sel_i;
        hz_src_match #(.REG_W(REG_W)) u_match (
            .src_id   (dec_src_ids[REG_W*i +: REG_W]),
            .ex_dst   (ex_dst),
            .mem_dst  (mem_dst),
            .wb_dst   (wb_dst),
            .ex_prod  (ex_prod),
            .mem_prod (mem_prod),
            .wb_prod  (wb_prod),
            .sel      (sel_i),
            .ex_hit   (ex_hits[i])
        );
        assign fwd_sel[2*i +: 2] = sel_i;
    end

    hz_ctrl u_ctrl (
        .ld_use_hit  (ld_use_d),
        .mispredict  (ex_mispredict),
        .stall       (stall_fd),
        .bubble      (bubble_ex),
        .flush_dec   (flush_dec),
        .flush_fetch (flush_fetch)
    );
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
    parameter int REG_W = 4,
    parameter int N_SRC = 2
) (
    input logic [N_SRC*REG_W-1:0] dec_src_ids,
    input logic [REG_W-1:0]       ex_dst,
    input logic                   ex_valid,
    input logic                   ex_wen,
    input logic                   ex_load,
    input logic [REG_W-1:0]       mem_dst,
    input logic                   mem_valid,
    input logic                   mem_wen,
    input logic [REG_W-1:0]       wb_dst,
    input logic                   wb_valid,
    input logic                   wb_wen,
    input logic                   ex_mispredict,
    input logic [2*N_SRC-1:0]     fwd_sel,
    input logic                   stall_fd,
    input logic                   bubble_ex,
    input logic                   flush_dec,
    input logic                   flush_fetch
);
    localparam logic [REG_W-1:0] NONE_ID = {REG_W{1'b1}};

    always_comb begin
        if (!$isunknown({dec_src_ids, ex_dst, ex_valid, ex_wen, ex_load, mem_dst,
                         mem_valid, mem_wen, wb_dst, wb_valid, wb_wen, ex_mispredict,
                         fwd_sel, stall_fd, bubble_ex, flush_dec, flush_fetch})) begin
            assert_stall_bubble_R6: assert (stall_fd == bubble_ex);
            assert_stall_cause_R6: assert (!stall_fd || (ex_load && ex_valid && ex_wen));
            assert_misp_squash_R8: assert (!ex_mispredict ||
                (flush_dec && flush_fetch && !stall_fd && !bubble_ex));
            assert_flush_pair_R8: assert (flush_dec == flush_fetch);
            assert_idle_R9: assert ((ex_valid || mem_valid || wb_valid) || fwd_sel == '0);
            for (int i = 0; i < N_SRC; i++) begin
                assert_none_id_R3: assert (dec_src_ids[REG_W*i +: REG_W] != NONE_ID ||
                                           fwd_sel[2*i +: 2] == 2'b00);
            end
        end
    end
endmodule

bind hazard_unit hazard_unit_chk #(.REG_W(REG_W), .N_SRC(N_SRC)) u_chk (.*);

// File: tb/sim_hazard_unit.sv
module sim_hazard_unit;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0] srcs;
    logic [3:0] ex_dst, mem_dst, wb_dst;
    logic ex_valid, ex_wen, ex_load, mem_valid, mem_wen, wb_valid, wb_wen, misp;
    logic [3:0] fwd_sel;
    logic stall_fd, bubble_ex, flush_dec, flush_fetch;

    hazard_unit u0 (
        .dec_src_ids(srcs), .ex_dst(ex_dst), .ex_valid(ex_valid), .ex_wen(ex_wen),
        .ex_load(ex_load), .mem_dst(mem_dst), .mem_valid(mem_valid), .mem_wen(mem_wen),
        .wb_dst(wb_dst), .wb_valid(wb_valid), .wb_wen(wb_wen), .ex_mispredict(misp),
        .fwd_sel(fwd_sel), .stall_fd(stall_fd), .bubble_ex(bubble_ex),
        .flush_dec(flush_dec), .flush_fetch(flush_fetch)
    );

    typedef struct packed {
        logic [3:0] rq;
        logic [3:0] sa, sb, exd;
        logic exv, exw, exl;
        logic [3:0] md;
        logic mv, mw;
        logic [3:0] wd;
        logic wv, ww, mp;
        logic [1:0] ea, eb;
        logic es, ef;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{4'd9,  4'd1, 4'd2, 4'd1, 1'b0,1'b1,1'b0, 4'd2,1'b0,1'b1, 4'd1,1'b0,1'b1, 1'b0, 2'b00,2'b00,1'b0,1'b0}, // R9
        '{4'd1,  4'd1, 4'd2, 4'd1, 1'b1,1'b1,1'b0, 4'd0,1'b0,1'b0, 4'd0,1'b0,1'b0, 1'b0, 2'b01,2'b00,1'b0,1'b0}, // R1
        '{4'd1,  4'd1, 4'd2, 4'd0, 1'b0,1'b0,1'b0, 4'd2,1'b1,1'b1, 4'd0,1'b0,1'b0, 1'b0, 2'b00,2'b10,1'b0,1'b0}, // R1
        '{4'd5,  4'd1, 4'd2, 4'd0, 1'b0,1'b0,1'b0, 4'd0,1'b0,1'b0, 4'd1,1'b1,1'b1, 1'b0, 2'b11,2'b00,1'b0,1'b0}, // R5
        '{4'd2,  4'd3, 4'd3, 4'd3, 1'b1,1'b1,1'b0, 4'd3,1'b1,1'b1, 4'd3,1'b1,1'b1, 1'b0, 2'b01,2'b01,1'b0,1'b0}, // R2
        '{4'd2,  4'd3, 4'd0, 4'd7, 1'b1,1'b1,1'b0, 4'd3,1'b1,1'b1, 4'd3,1'b1,1'b1, 1'b0, 2'b10,2'b00,1'b0,1'b0}, // R2
        '{4'd4,  4'd3, 4'd0, 4'd3, 1'b1,1'b0,1'b0, 4'd7,1'b1,1'b1, 4'd3,1'b1,1'b1, 1'b0, 2'b11,2'b00,1'b0,1'b0}, // R4
        '{4'd4,  4'd3, 4'd0, 4'd3, 1'b0,1'b1,1'b1, 4'd3,1'b1,1'b1, 4'd7,1'b1,1'b1, 1'b0, 2'b10,2'b00,1'b0,1'b0}, // R4
        '{4'd3,  4'd15,4'd15,4'd15,1'b1,1'b1,1'b1, 4'd15,1'b1,1'b1, 4'd15,1'b1,1'b1, 1'b0, 2'b00,2'b00,1'b0,1'b0}, // R3
        '{4'd6,  4'd4, 4'd0, 4'd4, 1'b1,1'b1,1'b1, 4'd0,1'b0,1'b0, 4'd0,1'b0,1'b0, 1'b0, 2'b01,2'b00,1'b1,1'b0}, // R6
        '{4'd6,  4'd0, 4'd4, 4'd4, 1'b1,1'b1,1'b1, 4'd0,1'b1,1'b1, 4'd0,1'b0,1'b0, 1'b0, 2'b10,2'b01,1'b1,1'b0}, // R6 R10
        '{4'd7,  4'd4, 4'd0, 4'd8, 1'b1,1'b1,1'b0, 4'd4,1'b1,1'b1, 4'd0,1'b0,1'b0, 1'b0, 2'b10,2'b00,1'b0,1'b0}, // R7
        '{4'd8,  4'd4, 4'd0, 4'd4, 1'b1,1'b1,1'b1, 4'd0,1'b0,1'b0, 4'd0,1'b0,1'b0, 1'b1, 2'b01,2'b00,1'b0,1'b1}, // R8
        '{4'd8,  4'd1, 4'd2, 4'd6, 1'b1,1'b1,1'b0, 4'd0,1'b0,1'b0, 4'd0,1'b0,1'b0, 1'b1, 2'b00,2'b00,1'b0,1'b1}, // R8
        '{4'd10, 4'd5, 4'd6, 4'd5, 1'b1,1'b1,1'b0, 4'd6,1'b1,1'b1, 4'd0,1'b0,1'b0, 1'b0, 2'b01,2'b10,1'b0,1'b0}, // R10
        '{4'd4,  4'd4, 4'd0, 4'd4, 1'b1,1'b0,1'b1, 4'd0,1'b0,1'b0, 4'd0,1'b0,1'b0, 1'b0, 2'b00,2'b00,1'b0,1'b0}  // R4
    };

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got sel/stall/bubble/flush %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        srcs = '0; ex_dst = '0; mem_dst = '0; wb_dst = '0;
        ex_valid = 0; ex_wen = 0; ex_load = 0; mem_valid = 0; mem_wen = 0;
        wb_valid = 0; wb_wen = 0; misp = 0;
    endtask

    initial begin
        drive_idle();
        @(negedge clk);
        // R9: idle pipeline after reset, register file selected everywhere
        check("R9", {fwd_sel, stall_fd, flush_dec}, 6'b0);
        check("R9", {2'b00, bubble_ex, flush_fetch, 2'b00}, 6'b0);

        for (int k = 0; k < NV; k++) begin
            @(posedge clk);
            srcs = {TBL[k].sb, TBL[k].sa};
            ex_dst = TBL[k].exd; ex_valid = TBL[k].exv; ex_wen = TBL[k].exw; ex_load = TBL[k].exl;
            mem_dst = TBL[k].md; mem_valid = TBL[k].mv; mem_wen = TBL[k].mw;
            wb_dst = TBL[k].wd; wb_valid = TBL[k].wv; wb_wen = TBL[k].ww;
            misp = TBL[k].mp;
            @(negedge clk);
            check($sformatf("R%0d vec%0d", TBL[k].rq, k),
                  {fwd_sel[3:2], fwd_sel[1:0], stall_fd, flush_dec},
                  {TBL[k].eb, TBL[k].ea, TBL[k].es, TBL[k].ef});
            check($sformatf("R%0d vec%0d b", TBL[k].rq, k),
                  {4'b0, bubble_ex, flush_fetch}, {4'b0, TBL[k].es, TBL[k].ef});
        end

        // R3 / R1: sweep every id through execute as a non-load producer
        for (int id = 0; id < 16; id++) begin
            @(posedge clk);
            drive_idle();
            srcs = {4'(id), 4'(id)};
            ex_dst = 4'(id); ex_valid = 1; ex_wen = 1;
            @(negedge clk);
            check(id == 15 ? "R3 sweep" : "R1 sweep", {fwd_sel, stall_fd, flush_dec},
                  id == 15 ? 6'b0 : 6'b010100);
        end

        // R5 sweep through writeback only
        for (int id = 0; id < 15; id++) begin
            @(posedge clk);
            drive_idle();
            srcs = {4'd15, 4'(id)};
            wb_dst = 4'(id); wb_valid = 1; wb_wen = 1;
            @(negedge clk);
            check("R5 sweep", {fwd_sel, stall_fd, flush_dec}, 6'b001100);
        end

        // R3: destination 15 with a real source of 15 only in one operand
        @(posedge clk);
        drive_idle();
        srcs = {4'd15, 4'd2}; ex_dst = 4'd15; ex_valid = 1; ex_wen = 1; ex_load = 1;
        @(negedge clk);
        check("R3 dst15 load", {fwd_sel, stall_fd, bubble_ex}, 6'b0);

        // R9: back to idle
        @(posedge clk);
        drive_idle();
        @(negedge clk);
        check("R9 return idle", {fwd_sel, stall_fd, flush_dec}, 6'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    int wd_cnt = 0;
    always @(posedge clk) begin
        wd_cnt <= wd_cnt + 1;
        if (wd_cnt > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule